// File: doc/BRIEF.md
# Adaptive Dead-Time Gate Sequencer

This block takes one PWM command and turns it into two gate enables for a synchronous buck power stage: one for the high-side switch and one for the low-side switch. The two enables are never on together. Dead time is not a fixed count. Each hand-over waits for feedback, and every feedback flag passes through a two-flop synchronizer before the sequencer uses it. When the high side releases, the low side waits for a comparator to report that the switch node has fallen. When the low side releases, the high side waits for a comparator to report that the low-side gate voltage has collapsed.

Sometimes the inductor current is negative and the switch node never falls. For that case a watchdog counts cycles from high-side release and turns the low side on anyway, so that current can recirculate. A mode manager drives a run qualifier that parks both switches off. An overvoltage protection path drives a force request that clamps the low side on.

Top module: `gate_sequencer`

## Requirements
- R1: `hs_gate` and `ls_gate` are never both 1 in the same cycle.
- R2: With `run_en`=1, a 1-to-0 change of `pwm_in` clears `hs_gate` on the next clock edge. `ls_gate` rises on the third edge after `sw_low_raw` reads 1 (two synchronizer flops plus the state register).
- R3: With `run_en`=1, a 0-to-1 change of `pwm_in` clears `ls_gate` on the next clock edge. `hs_gate` stays 0 until `lsg_low_raw` reads 1, and rises on the third edge after that.
- R4: If the synchronized phase flag stays 0 after high-side release, `ls_gate` rises exactly `WDOG_CYCLES`+1 edges after the `pwm_in` fall. If the flag rises earlier, it wins and the watchdog is cancelled.
- R5: A `pwm_in` change during either wait state aborts that wait and starts the opposite sequence, with both gates low for at least one cycle in between.
- R6: While `run_en`=0 and `force_ls`=0, both gates are 0 from the next edge on, whatever `pwm_in` does.
- R7: While `force_ls`=1, `hs_gate` is 0 from the next edge and `ls_gate` is 1 from the second edge on. This holds whatever `pwm_in` and `run_en` do.
- R8: After reset both gates are 0. Once `run_en` returns to 1, normal sequencing resumes from the current `pwm_in` level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pwm_in | input | 1 | PWM command: 1 selects the high side, 0 selects the low side |
| run_en | input | 1 | Run qualifier; 0 parks both gates off |
| sw_low_raw | input | 1 | Asynchronous flag, 1 when the switch node is below its threshold |
| lsg_low_raw | input | 1 | Asynchronous flag, 1 when the low-side gate voltage is below its threshold |
| force_ls | input | 1 | Protection request that clamps the low side on |
| hs_gate | output | 1 | High-side gate enable |
| ls_gate | output | 1 | Low-side gate enable |

## Verification
A falling `pwm_in` is tested two ways: with the phase flag arriving promptly, and with the flag arriving mid-wait. Comparing the two separates the flag-driven hand-over from the watchdog path. A third falling edge has the flag held low for good, which pins the watchdog to its exact expiry cycle. A rising `pwm_in` is held in the wait state with the gate flag low, which shows that no timeout can bring the high side on. A `pwm_in` reversal inside each wait state tests the abort paths. Toggling `pwm_in` while the block is disabled or forced shows that those qualifiers override the command.

// File: rtl/gate_sequencer.sv
module gate_sequencer #(
  parameter int WDOG_CYCLES = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pwm_in,
  input  logic run_en,
  input  logic sw_low_raw,
  input  logic lsg_low_raw,
  input  logic force_ls,
  output logic hs_gate,
  output logic ls_gate
);
  localparam int CW = $clog2(WDOG_CYCLES + 1);

  typedef enum logic [2:0] {
    IDLE_OFF, HS_ON, WAIT_PHASE_LOW, LS_ON, WAIT_LGATE_LOW
  } seq_t;

  seq_t state, nxt;
  logic [SYNC_STAGES-1:0] sw_sync, lg_sync;
  logic [CW-1:0] wdog_cnt;
  logic sw_low, lg_low, wdog_done;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sw_sync <= '0;
      lg_sync <= '0;
    end else begin
      sw_sync <= {sw_sync[SYNC_STAGES-2:0], sw_low_raw};
      lg_sync <= {lg_sync[SYNC_STAGES-2:0], lsg_low_raw};
    end

  assign sw_low    = sw_sync[SYNC_STAGES-1];
  assign lg_low    = lg_sync[SYNC_STAGES-1];
  assign wdog_done = (wdog_cnt == CW'(WDOG_CYCLES - 1));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                      wdog_cnt <= '0;
    else if (state != WAIT_PHASE_LOW) wdog_cnt <= '0;
    else if (!wdog_done)             wdog_cnt <= wdog_cnt + 1'b1;

  always_comb begin
    nxt = state;
    if (force_ls) begin
      nxt = (state == HS_ON) ? WAIT_PHASE_LOW : LS_ON;
    end else if (!run_en) begin
      nxt = IDLE_OFF;
    end else begin
      case (state)
        IDLE_OFF:       nxt = pwm_in ? WAIT_LGATE_LOW : WAIT_PHASE_LOW;
        HS_ON:          if (!pwm_in) nxt = WAIT_PHASE_LOW;
        WAIT_PHASE_LOW: if (pwm_in) nxt = WAIT_LGATE_LOW;
                        else if (sw_low || wdog_done) nxt = LS_ON;
        LS_ON:          if (pwm_in) nxt = WAIT_LGATE_LOW;
        WAIT_LGATE_LOW: if (!pwm_in) nxt = WAIT_PHASE_LOW;
                        else if (lg_low) nxt = HS_ON;
        default:        nxt = IDLE_OFF;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) state <= IDLE_OFF;
    else        state <= nxt;

  assign hs_gate = (state == HS_ON);
  assign ls_gate = (state == LS_ON);
endmodule

// File: rtl/gate_sequencer_chk.sv
module gate_sequencer_chk (
  input logic clk,
  input logic rst_n,
  input logic pwm_in,
  input logic run_en,
  input logic force_ls,
  input logic hs_gate,
  input logic ls_gate
);
  AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
    !(hs_gate && ls_gate)); // R1
  AST_LS_AFTER_HS_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ls_gate) |-> !$past(hs_gate)); // R2
  AST_LS_RISE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ls_gate) |-> $past(!pwm_in || force_ls)); // R2
  AST_HS_AFTER_LS_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hs_gate) |-> !$past(ls_gate)); // R3
  AST_HS_RISE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hs_gate) |-> $past(pwm_in && run_en && !force_ls)); // R3
  AST_DISABLE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_en && !force_ls) |=> (!hs_gate && !ls_gate)); // R6
  AST_FORCE_HS_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    force_ls |=> !hs_gate); // R7
  AST_FORCE_LS_ON: assert property (@(posedge clk) disable iff (!rst_n)
    (force_ls && $past(force_ls)) |=> ls_gate); // R7
endmodule

bind gate_sequencer gate_sequencer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .pwm_in(pwm_in), .run_en(run_en),
  .force_ls(force_ls), .hs_gate(hs_gate), .ls_gate(ls_gate)
);

// File: tb/tb_gate_sequencer.sv
module tb_gate_sequencer;
  localparam int PERIOD = 10;
  localparam int WD = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic pwm_in = 1'b0, run_en = 1'b1, sw_low_raw = 1'b1, lsg_low_raw = 1'b1, force_ls = 1'b0;
  logic hs_gate, ls_gate;
  int checks = 0, errors = 0;
  bit finished = 1'b0;

  gate_sequencer #(.WDOG_CYCLES(WD)) dut (
    .clk(clk), .rst_n(rst_n), .pwm_in(pwm_in), .run_en(run_en),
    .sw_low_raw(sw_low_raw), .lsg_low_raw(lsg_low_raw), .force_ls(force_ls),
    .hs_gate(hs_gate), .ls_gate(ls_gate)
  );

  always #(PERIOD/2) clk = ~clk;

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input string rq, input logic [1:0] exp);
    checks++;
    if ({hs_gate, ls_gate} !== exp) begin
      errors++;
      $display("FAIL %s: {hs,ls} actual=%b expected=%b at %0t", rq, {hs_gate, ls_gate}, exp, $time);
    end
  endtask

  task automatic go_hs();
    sw_low_raw = 1'b0; lsg_low_raw = 1'b1; pwm_in = 1'b1;
    step(5);
    chk("R3 setup hs on", 2'b10);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; step(2);
    chk("R8 reset both off", 2'b00);
    rst_n = 1'b1; step(6);
    chk("R8 resumes low side", 2'b01);
  endtask

  task automatic t_fall_flag();
    go_hs();
    pwm_in = 1'b0; sw_low_raw = 1'b1;
    step(1); chk("R2 hs drops next edge", 2'b00);
    step(1); chk("R2 ls waits synchronizer", 2'b00);
    step(1); chk("R2 ls on third edge", 2'b01);
  endtask

  task automatic t_rise_flag();
    lsg_low_raw = 1'b0; step(3);
    pwm_in = 1'b1;
    step(1); chk("R3 ls drops next edge", 2'b00);
    step(20); chk("R3 hs waits for gate flag", 2'b00);
    lsg_low_raw = 1'b1;
    step(2); chk("R3 hs waits synchronizer", 2'b00);
    step(1); chk("R3 hs on third edge", 2'b10);
  endtask

  task automatic t_watchdog();
    go_hs();
    pwm_in = 1'b0;
    step(WD); chk("R4 before expiry", 2'b00);
    step(1); chk("R4 watchdog expiry", 2'b01);
  endtask

  task automatic t_wdog_cancel();
    go_hs();
    pwm_in = 1'b0;
    step(3); sw_low_raw = 1'b1;
    step(2); chk("R4 flag mid-wait pending", 2'b00);
    step(1); chk("R4 flag beats watchdog", 2'b01);
  endtask

  task automatic t_abort();
    go_hs();
    pwm_in = 1'b0;
    step(2); chk("R5 in phase wait", 2'b00);
    pwm_in = 1'b1;
    step(1); chk("R5 abort to gate wait", 2'b00);
    step(1); chk("R5 hs after abort", 2'b10);
    lsg_low_raw = 1'b0; sw_low_raw = 1'b1;
    pwm_in = 1'b0; step(3); chk("R5 ls on", 2'b01);
    pwm_in = 1'b1; step(3); chk("R5 in gate wait", 2'b00);
    pwm_in = 1'b0;
    step(1); chk("R5 abort to phase wait", 2'b00);
    step(1); chk("R5 ls after abort", 2'b01);
    lsg_low_raw = 1'b1;
  endtask

  task automatic t_disable();
    go_hs();
    run_en = 1'b0;
    step(1); chk("R6 disable drops hs", 2'b00);
    for (int i = 0; i < 4; i++) begin
      pwm_in = ~pwm_in; step(2); chk("R6 pwm ignored", 2'b00);
    end
    pwm_in = 1'b1; run_en = 1'b1;
    step(1); chk("R8 re-enable break first", 2'b00);
    step(1); chk("R8 re-enable hs", 2'b10);
  endtask

  task automatic t_force();
    go_hs();
    force_ls = 1'b1;
    step(1); chk("R7 force drops hs", 2'b00);
    step(1); chk("R7 force ls on", 2'b01);
    pwm_in = 1'b0; step(2); pwm_in = 1'b1; step(2);
    chk("R7 pwm ignored under force", 2'b01);
    run_en = 1'b0; step(2);
    chk("R7 force beats disable", 2'b01);
    force_ls = 1'b0;
    step(1); chk("R6 release into disable", 2'b00);
    force_ls = 1'b1;
    step(1); chk("R7 force from idle", 2'b01);
    force_ls = 1'b0; run_en = 1'b1; step(4);
  endtask

  initial begin
    #(PERIOD * 50000);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_fall_flag();
    t_rise_flag();
    t_watchdog();
    t_wdog_cancel();
    t_abort();
    t_disable();
    t_force();
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule